// File: doc/BRIEF.md
# Multi-Master Doorbell Interrupt Unit

This block gives a chip a set of doorbell channels through which up to 32 bus masters can signal one another. Every doorbell belongs to one receiving master. Any master rings a doorbell by writing its ring register. The unit takes the writer's identity from a sideband master-ID input that comes with every bus write, and records the ring in a per-master bit. The receiver sets a per-master enable mask that decides which ringers can raise its interrupt.

Each doorbell keeps three bit vectors with one bit per master ID: an enable mask, a raw history of every ring, and a pending vector that holds only the enabled rings. The receiver's interrupt line is high while its pending vector is non-zero. Software reads the pending value and writes the same value back. Every bit written as one is cleared from both pending and raw, so the receiver can acknowledge rings one ringer at a time.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every enable, raw and pending vector is zero, every interrupt output is low, and every register reads zero.
- R2: A write to a doorbell's ring register (offset 0x0) with data bit 0 set sets raw bit `mid_i` of that doorbell at the next clock edge. A ring write with bit 0 clear changes nothing.
- R3: A ring from master `mid_i` sets pending bit `mid_i` only when enable bit `mid_i` of that doorbell is set. The raw bit is set whatever the enable bit holds.
- R4: The enable register (offset 0x4) is read/write, and bit k of the written data holds the enable for master ID k.
- R5: A write to the pending register (offset 0xC) clears, in both the pending and the raw vector, every bit written as one, and leaves every bit written as zero unchanged.
- R6: `irq_o[n]` is high exactly when doorbell n has at least one pending bit set. It rises one cycle after the ring write and falls one cycle after the clearing write.
- R7: Doorbell n occupies the 0x100-byte window that starts at byte address n*0x100. The ring register always reads zero. Addresses other than 0x0, 0x4, 0x8 and 0xC inside a window read zero, and writes to them have no effect. A write to one doorbell leaves the others unchanged.
- R8: Writes to the raw register (offset 0x8) have no effect. It is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (10) | Byte address: doorbell index above bit 7, register offset in bits 7:0 |
| wdata_i | input | 32 | Write data |
| mid_i | input | MID_W (5) | ID of the master making the access |
| rdata_o | output | 32 | Read data, valid in the same cycle while req_i is high and we_i is low |
| irq_o | output | NUM_DB (4) | One interrupt per doorbell, high while any of its pending bits is set |

## Verification
On every cycle the assertions check that pending never holds a bit that raw lacks, that a write adds at most one new ring, that no new pending bit appears for a master that was not enabled, and that the raw state stays still when no write occurs. They also check that an interrupt only falls after a write, and that an interrupt line is never high without recorded rings. Only the bench scenarios can show that the exact bit `mid_i` is recorded, that ring data with bit 0 clear is ignored, that enable values read back, and that partial write-one-to-clear masks leave the right bits behind. The address map, including the dead offsets and the read-only raw register, is also shown only by those scenarios.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int WIN_BITS = 8;  // 0x100-byte window per doorbell
  localparam int DATA_W   = 32;

  typedef enum logic [1:0] {
    REG_RING = 2'd0,
    REG_EN   = 2'd1,
    REG_RAW  = 2'd2,
    REG_PEND = 2'd3
  } db_reg_e;
endpackage

// File: rtl/db_decode.sv
module db_decode
  import db_pkg::*;
#(
  parameter int NUM_DB = 4,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = IDX_W + WIN_BITS
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output db_reg_e           kind_o,
  output logic [NUM_DB-1:0] sel_o
);
  logic idx_ok;
  logic off_ok;

  assign idx_o  = addr_i[ADDR_W-1:WIN_BITS];
  assign kind_o = db_reg_e'(addr_i[3:2]);
  assign off_ok = (addr_i[WIN_BITS-1:4] == '0) && (addr_i[1:0] == 2'b00);

  generate
    if (NUM_DB == (1 << IDX_W)) begin : g_full
      assign idx_ok = 1'b1;
    end else begin : g_part
      assign idx_ok = (int'(idx_o) < NUM_DB);
    end
  endgenerate

  assign hit_o = req_i && off_ok && idx_ok;

  for (genvar n = 0; n < NUM_DB; n++) begin : g_sel
    assign sel_o[n] = hit_o && (idx_o == IDX_W'(n));
  end
endmodule

// File: rtl/db_channel.sv
module db_channel
  import db_pkg::*;
#(
  parameter int NUM_MST = 32,
  parameter int MID_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  db_reg_e            kind_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [MID_W-1:0]   mid_i,
  output logic [NUM_MST-1:0] en_o,
  output logic [NUM_MST-1:0] raw_o,
  output logic [NUM_MST-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_MST-1:0] en_q, raw_q, pend_q;
  logic [NUM_MST-1:0] ring_vec, clr_vec;
  logic               mid_ok;

  generate
    if (NUM_MST == (1 << MID_W)) begin : g_mid_full
      assign mid_ok = 1'b1;
    end else begin : g_mid_part
      assign mid_ok = (int'(mid_i) < NUM_MST);
    end
  endgenerate

  always_comb begin
    ring_vec = '0;
    if (wr_i && (kind_i == REG_RING) && wdata_i[0] && mid_ok)
      ring_vec[mid_i] = 1'b1;
  end

  assign clr_vec = (wr_i && (kind_i == REG_PEND)) ? wdata_i[NUM_MST-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_i && (kind_i == REG_EN)) en_q <= wdata_i[NUM_MST-1:0];
      // new ring wins over a clear of the same bit
      raw_q  <= (raw_q & ~clr_vec) | ring_vec;
      pend_q <= (pend_q & ~clr_vec) | (ring_vec & en_q);
    end
  end

  assign en_o   = en_q;
  assign raw_o  = raw_q;
  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/db_rdmux.sv
module db_rdmux
  import db_pkg::*;
#(
  parameter int NUM_DB  = 4,
  parameter int NUM_MST = 32,
  parameter int IDX_W   = 2,
  localparam int VEC_W  = NUM_DB * NUM_MST
) (
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  db_reg_e           kind_i,
  input  logic [VEC_W-1:0]  en_all_i,
  input  logic [VEC_W-1:0]  raw_all_i,
  input  logic [VEC_W-1:0]  pend_all_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (kind_i)
        REG_EN:   rdata_o[NUM_MST-1:0] = en_all_i[int'(idx_i)*NUM_MST +: NUM_MST];
        REG_RAW:  rdata_o[NUM_MST-1:0] = raw_all_i[int'(idx_i)*NUM_MST +: NUM_MST];
        REG_PEND: rdata_o[NUM_MST-1:0] = pend_all_i[int'(idx_i)*NUM_MST +: NUM_MST];
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import db_pkg::*;
#(
  parameter int NUM_DB   = 4,
  parameter int NUM_MST  = 32,
  localparam int IDX_W   = (NUM_DB > 1) ? $clog2(NUM_DB) : 1,
  localparam int MID_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
  localparam int ADDR_W  = IDX_W + WIN_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [MID_W-1:0]  mid_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_DB-1:0] irq_o
);
  localparam int VEC_W = NUM_DB * NUM_MST;

  logic              hit;
  logic [IDX_W-1:0]  idx;
  db_reg_e           kind;
  logic [NUM_DB-1:0] sel;
  logic [VEC_W-1:0]  en_all, raw_all, pend_all;

  db_decode #(
    .NUM_DB(NUM_DB),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W)
  ) u_decode (
    .req_i (req_i),
    .addr_i(addr_i),
    .hit_o (hit),
    .idx_o (idx),
    .kind_o(kind),
    .sel_o (sel)
  );

  for (genvar n = 0; n < NUM_DB; n++) begin : g_db
    db_channel #(
      .NUM_MST(NUM_MST),
      .MID_W  (MID_W)
    ) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (sel[n] && we_i),
      .kind_i (kind),
      .wdata_i(wdata_i),
      .mid_i  (mid_i),
      .en_o   (en_all[n*NUM_MST +: NUM_MST]),
      .raw_o  (raw_all[n*NUM_MST +: NUM_MST]),
      .pend_o (pend_all[n*NUM_MST +: NUM_MST]),
      .irq_o  (irq_o[n])
    );
  end

  db_rdmux #(
    .NUM_DB (NUM_DB),
    .NUM_MST(NUM_MST),
    .IDX_W  (IDX_W)
  ) u_rdmux (
    .rd_i      (hit && !we_i),
    .idx_i     (idx),
    .kind_i    (kind),
    .en_all_i  (en_all),
    .raw_all_i (raw_all),
    .pend_all_i(pend_all),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/doorbell_unit_chk.sv
module doorbell_unit_chk #(
  parameter int NUM_DB  = 4,
  parameter int NUM_MST = 32,
  localparam int VEC_W  = NUM_DB * NUM_MST
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [NUM_DB-1:0] irq_o,
  input logic [VEC_W-1:0]  en_all,
  input logic [VEC_W-1:0]  raw_all,
  input logic [VEC_W-1:0]  pend_all
);
  a_r3_pend_within_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_all & ~raw_all) == '0);

  a_r2_idle_raw_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(raw_all));

  a_r2_one_ring_per_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(raw_all & ~$past(raw_all)) <= 1);

  a_r3_enable_gates_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_all & ~$past(pend_all) & ~$past(en_all)) == '0);

  for (genvar n = 0; n < NUM_DB; n++) begin : g_irq
    a_r6_irq_has_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> (raw_all[n*NUM_MST +: NUM_MST] != '0));

    a_r5_irq_falls_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[n]) |-> $past(req_i && we_i));
  end
endmodule

bind doorbell_unit doorbell_unit_chk #(
  .NUM_DB (NUM_DB),
  .NUM_MST(NUM_MST)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .irq_o   (irq_o),
  .en_all  (en_all),
  .raw_all (raw_all),
  .pend_all(pend_all)
);

// File: tb/doorbell_unit_tb.sv
module doorbell_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDB = 4;
  localparam int NM  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  mid = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_en[NDB];
  logic [31:0] m_raw[NDB];
  logic [31:0] m_pend[NDB];

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_unit #(.NUM_DB(NDB), .NUM_MST(NM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mid_i(mid), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int db, input logic [7:0] off, input logic [31:0] d, input int m);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {2'(db), off}; wdata = d; mid = 5'(m);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    case (off)
      8'h00: if (d[0]) begin
        m_raw[db][m] = 1'b1;
        if (m_en[db][m]) m_pend[db][m] = 1'b1;
      end
      8'h04: m_en[db] = d;
      8'h0C: begin
        m_raw[db]  = m_raw[db] & ~d;
        m_pend[db] = m_pend[db] & ~d;
      end
      default: ;
    endcase
  endtask

  task automatic rd(input int db, input logic [7:0] off, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = {2'(db), off};
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic check_db(input int db, input string ph);
    logic [31:0] v;
    rd(db, 8'h04, v); chk($sformatf("R4 %s db%0d enable", ph, db), v, m_en[db]);
    rd(db, 8'h08, v); chk($sformatf("R2 %s db%0d raw", ph, db), v, m_raw[db]);
    rd(db, 8'h0C, v); chk($sformatf("R3 %s db%0d pending", ph, db), v, m_pend[db]);
    rd(db, 8'h00, v); chk($sformatf("R7 %s db%0d ring reads 0", ph, db), v, 32'h0);
    chk($sformatf("R6 %s db%0d irq", ph, db), {31'h0, irq[db]}, {31'h0, |m_pend[db]});
  endtask

  task automatic check_all(input string ph);
    for (int d = 0; d < NDB; d++) check_db(d, ph);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int d = 0; d < NDB; d++) begin
      m_en[d] = '0; m_raw[d] = '0; m_pend[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_all("R1 reset");

    // R4: enable patterns per doorbell
    wr(0, 8'h04, 32'h0000_0000, 3);
    wr(1, 8'h04, 32'hFFFF_FFFF, 7);
    wr(2, 8'h04, 32'h5555_AAAA, 0);
    wr(3, 8'h04, 32'h0F0F_3C3C, 31);
    check_all("R4 enable");

    // R2 R3 R6: ring from every master on every doorbell, plus bit0-clear writes
    for (int d = 0; d < NDB; d++) begin
      for (int m = 0; m < NM; m++) begin
        wr(d, 8'h00, 32'hFFFF_FFFE, m);
        check_db(d, "R2 bit0 clear");
        wr(d, 8'h00, 32'h1 | (32'(m) << 4), m);
        check_db(d, "R3 ring");
      end
      check_all("R7 isolation");
    end

    // R8: raw register is read-only
    for (int d = 0; d < NDB; d++) wr(d, 8'h08, 32'h0000_0000, d);
    check_all("R8 raw write");

    // R7: dead offsets ignored and read zero
    for (int d = 0; d < NDB; d++) begin
      wr(d, 8'h10, 32'hFFFF_FFFF, 2);
      wr(d, 8'h84, 32'h0000_0000, 2);
      wr(d, 8'h0D, 32'hFFFF_FFFF, 2);
      rd(d, 8'h10, v); chk($sformatf("R7 db%0d offset 0x10", d), v, 32'h0);
      rd(d, 8'hFC, v); chk($sformatf("R7 db%0d offset 0xFC", d), v, 32'h0);
    end
    check_all("R7 dead offsets");

    // R5: partial clear, re-ring, full clear
    for (int d = 0; d < NDB; d++) wr(d, 8'h0C, 32'h0000_FFFF, 0);
    check_all("R5 partial clear");
    wr(2, 8'h00, 32'h1, 1);
    wr(2, 8'h00, 32'h1, 2);
    wr(3, 8'h04, 32'h0000_0010, 9);
    wr(3, 8'h00, 32'h1, 4);
    check_all("R5 re-ring");
    wr(3, 8'h0C, 32'h0000_0010, 4);
    check_db(3, "R5 clear one");
    for (int d = 0; d < NDB; d++) wr(d, 8'h0C, 32'hFFFF_FFFF, 0);
    check_all("R5 full clear");
    chk("R6 all irq low", {28'h0, irq}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule